// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Model

This block is a synthesizable model of a flow-through synchronous static RAM in which read and write cycles may follow each other in any order on consecutive clocks, with no idle cycle in between. Address and control are captured on a rising edge. The data belonging to that cycle moves one cycle later. For a read, the array word is presented combinationally during the next cycle. For a write, the data word is captured at the edge that ends the next cycle.

A cycle is started with the start/advance input low while all three chip selects are active. With start/advance high, a running burst steps through four words. The order is either linear or interleaved, chosen by a mode input. A low-true clock enable stalls the whole block. Per-byte write enables limit which lanes of a word a write updates. The bidirectional data bus is split into a write-data input and a read-data output, and a valid flag marks the read-data cycles.

Top module: `zt_sram`

## Requirements
- R1: A read accepted at edge e (startN low, all selects active, rdWr=1) drives rdValid=1 and rdData equal to the stored word at that address during the cycle after e.
- R2: A write accepted at edge e (rdWr=0) stores the wrData present at the next enabled edge. Any sequence of reads and writes, including a read of the same address one cycle after a write, needs no idle cycle and returns the newly written data.
- R3: While clkEnN=1, every synchronous input is ignored. No pipeline or burst state changes, no write is performed, and rdValid and rdData hold their values.
- R4: A new access starts only when startN=0 with selA=0, selB=1 and selC=0. If any select is inactive, no access starts and rdValid is 0 in the following cycle.
- R5: A deselect cycle ends any burst, and later cycles with startN=1 perform no access. A read accepted one cycle before the deselect still shows its data during the deselect cycle.
- R6: With burstIlv=0, beat k of a burst addresses the starting address with its low two bits replaced by (start+k) mod 4.
- R7: With burstIlv=1, beat k of a burst addresses the starting address with its low two bits replaced by start XOR k.
- R8: For a write, byteWrN bit i = 0 updates bits [8i+7:8i] of the word, and a lane with byteWrN bit i = 1 keeps its old contents. The byteWrN value used is the one sampled with the address.
- R9: A cycle with startN=1 during a burst keeps the direction of the burst's first cycle, whatever rdWr is.
- R10: After reset, and in every cycle that carries no read data, rdValid=0 and rdData=0.
- R11: A burst continued past four beats wraps, so beat k uses k mod 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEnN | input | 1 | Clock enable, active low; high stalls the block |
| startN | input | 1 | Low starts a new cycle, high advances a burst |
| rdWr | input | 1 | Direction of a new cycle: 1 read, 0 write |
| selA | input | 1 | Chip select, active low |
| selB | input | 1 | Chip select, active high |
| selC | input | 1 | Chip select, active low |
| burstIlv | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| byteWrN | input | LANES | Per-lane write enables, active low |
| wrData | input | LANES*LANE_W | Write data, sampled one cycle after its address |
| rdData | output | LANES*LANE_W | Read data, zero when not valid |
| rdValid | output | 1 | High in cycles carrying read data |

## Verification
The hardest case to reach from the ports is a stall that falls between a write's address and its data, or in the middle of a burst. In that case the bench must show that the data sampled at the stalled edge is discarded and that the burst resumes at the correct beat. The stimulus inserts several stalled cycles carrying garbage on every input inside both read and write bursts, in both burst orders. The following reads are compared against a reference array that the bench updates only at enabled edges. The array is first filled by a full address sweep of back-to-back writes. Each of the three selects is then made inactive in turn, both at a burst start and right after an accepted read.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  // strobes from control to datapath, valid during the data phase
  typedef struct packed {
    logic rd;
    logic wr;
  } zt_strobe_t;

  // low two address bits of burst beat k
  function automatic logic [1:0] burstLow(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic ilv);
    burstLow = ilv ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/zt_sram_ctrl.sv
module zt_sram_ctrl
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic              startN,
  input  logic              rdWr,
  input  logic              selOk,
  input  logic              burstIlv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  byteWrN,
  output zt_strobe_t        strb,
  output logic [ADDR_W-1:0] phAddr,
  output logic [LANES-1:0]  phLanes
);

  logic              burstOn;
  logic              burstRd;
  logic [ADDR_W-1:0] baseAddr;
  logic [1:0]        beat;

  logic              newOp;
  logic              advOp;
  logic              anyOp;
  logic              opRd;
  logic [1:0]        beatNext;
  logic [ADDR_W-1:0] accAddr;

  always_comb begin
    newOp    = !startN && selOk;
    advOp    = startN && burstOn;
    anyOp    = newOp || advOp;
    opRd     = newOp ? rdWr : burstRd;
    beatNext = beat + 2'd1;
    if (newOp) begin
      accAddr = addr;
    end else begin
      accAddr = {baseAddr[ADDR_W-1:2], burstLow(baseAddr[1:0], beatNext, burstIlv)};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstOn  <= 1'b0;
      burstRd  <= 1'b0;
      baseAddr <= '0;
      beat     <= '0;
    end else if (en) begin
      if (!startN) begin
        burstOn <= selOk;
        if (selOk) begin
          baseAddr <= addr;
          beat     <= '0;
          burstRd  <= rdWr;
        end
      end else if (burstOn) begin
        beat <= beatNext;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strb    <= '0;
      phAddr  <= '0;
      phLanes <= '0;
    end else if (en) begin
      strb.rd <= anyOp && opRd;
      strb.wr <= anyOp && !opRd;
      phAddr  <= accAddr;
      phLanes <= ~byteWrN;
    end
  end

endmodule

// File: rtl/zt_sram_dp.sv
module zt_sram_dp
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              en,
  input  zt_strobe_t        strb,
  input  logic [ADDR_W-1:0] phAddr,
  input  logic [LANES-1:0]  phLanes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] oldWord;
  logic [DATA_W-1:0] newWord;

  assign oldWord = mem[phAddr];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign newWord[g*LANE_W +: LANE_W] = phLanes[g] ? wrData[g*LANE_W +: LANE_W]
                                                    : oldWord[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (en && strb.wr) begin
      mem[phAddr] <= newWord;
    end
  end

  assign rdValid = strb.rd;
  assign rdData  = strb.rd ? oldWord : '0;

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              startN,
  input  logic              rdWr,
  input  logic              selA,
  input  logic              selB,
  input  logic              selC,
  input  logic              burstIlv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  byteWrN,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic              en;
  logic              selOk;
  zt_strobe_t        strb;
  logic [ADDR_W-1:0] phAddr;
  logic [LANES-1:0]  phLanes;

  assign en    = !clkEnN;
  assign selOk = !selA && selB && !selC;

  zt_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) ctrl_i (
    .clk(clk), .rstN(rstN), .en(en), .startN(startN), .rdWr(rdWr),
    .selOk(selOk), .burstIlv(burstIlv), .addr(addr), .byteWrN(byteWrN),
    .strb(strb), .phAddr(phAddr), .phLanes(phLanes)
  );

  zt_sram_dp #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dp_i (
    .clk(clk), .en(en), .strb(strb), .phAddr(phAddr), .phLanes(phLanes),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEnN,
  input logic              startN,
  input logic              rdWr,
  input logic              selA,
  input logic              selB,
  input logic              selC,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid
);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> ($stable(rdValid) && $stable(rdData)));

  // R4
  desel_noop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !startN && !(!selA && selB && !selC)) |=> !rdValid);

  // R1
  read_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !startN && !selA && selB && !selC && rdWr) |=> rdValid);

  // R2
  write_no_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !startN && !selA && selB && !selC && !rdWr) |=> !rdValid);

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0));

endmodule

bind zt_sram zt_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) chk_i (
  .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .startN(startN), .rdWr(rdWr),
  .selA(selA), .selB(selB), .selC(selC), .rdData(rdData), .rdValid(rdValid)
);

// File: tb/zt_sram_tb_top.sv
module zt_sram_tb_top;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int DW = NL * 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkEnN = 1'b0, startN = 1'b1, rdWr = 1'b1;
  logic selA = 1'b0, selB = 1'b1, selC = 1'b0, burstIlv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NL-1:0] byteWrN = '1;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic rdValid;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] refMem [DEPTH];
  logic pRd = 1'b0, pWr = 1'b0;
  logic [AW-1:0] pAddr = '0;
  logic [NL-1:0] pLanes = '0;
  logic bOn = 1'b0, bRd = 1'b0;
  logic [AW-1:0] bBase = '0;
  int bBeat = 0;

  always #10 clk = ~clk;

  zt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .startN(startN), .rdWr(rdWr),
    .selA(selA), .selB(selB), .selC(selC), .burstIlv(burstIlv), .addr(addr),
    .byteWrN(byteWrN), .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

  function automatic logic [AW-1:0] beatAddr(logic [AW-1:0] b, int k, logic ilv);
    logic [1:0] lo;
    lo = ilv ? (b[1:0] ^ 2'(k % 4)) : 2'((b[1:0] + k) % 4);
    return {b[AW-1:2], lo};
  endfunction

  function automatic logic [DW-1:0] pat(int a, int salt);
    return 32'(a * 32'h01030507) ^ 32'(salt * 32'h9E3779B9);
  endfunction

  task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  // one clock: inputs applied now (after negedge), model advanced at the edge, output checked after it
  task automatic cyc(string tag, logic cen, logic st, logic rw, logic [AW-1:0] a,
                     logic [NL-1:0] bwn, logic [DW-1:0] wd,
                     logic sa = 1'b0, logic sb = 1'b1, logic sc = 1'b0);
    logic ok;
    clkEnN = cen; startN = st; rdWr = rw; addr = a; byteWrN = bwn; wrData = wd;
    selA = sa; selB = sb; selC = sc;
    @(posedge clk);
    if (!cen) begin
      if (pWr) begin
        for (int i = 0; i < NL; i++)
          if (pLanes[i]) refMem[pAddr][i*8 +: 8] = wd[i*8 +: 8];
      end
      ok = !sa && sb && !sc;
      if (!st) begin
        bOn = ok;
        if (ok) begin bBase = a; bBeat = 0; bRd = rw; end
        pRd = ok && rw; pWr = ok && !rw; pAddr = a;
      end else if (bOn) begin
        bBeat++;
        pRd = bRd; pWr = !bRd; pAddr = beatAddr(bBase, bBeat, burstIlv);
      end else begin
        pRd = 1'b0; pWr = 1'b0;
      end
      pLanes = ~bwn;
    end
    #2;
    check({tag, " valid"}, {31'd0, rdValid}, {31'd0, pRd});
    check({tag, " data"}, rdData, pRd ? refMem[pAddr] : '0);
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset valid", {31'd0, rdValid}, 32'd0);
    check("R10 reset data", rdData, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 fill sweep of back-to-back writes; each data word rides with the next cycle
    for (int a = 0; a <= DEPTH; a++)
      cyc("R2 fill", 0, (a == DEPTH), 0, AW'(a), '0, (a == 0) ? '0 : pat(a - 1, 1));
    // R1 read sweep back-to-back
    for (int a = 0; a < DEPTH; a++) cyc("R1 sweep", 0, 0, 1, AW'(a), '1, '0);
    cyc("R10 idle", 0, 1, 1, '0, '1, '0, 1'b1);

    // R2 write then read of same address on the next cycle
    for (int a = 0; a < 16; a++) begin
      cyc("R2 wr", 0, 0, 0, AW'(a * 3), '0, '0);
      cyc("R2 rd-after-wr", 0, 0, 1, AW'(a * 3), '1, pat(a, 7));
    end
    cyc("R10 idle", 0, 0, 1, '0, '1, '0, 1'b1);

    // R6 / R7 / R11 read bursts from every start offset, six beats each
    for (int m = 0; m < 2; m++) begin
      burstIlv = m[0];
      for (int s = 0; s < 4; s++) begin
        cyc(m ? "R7 start" : "R6 start", 0, 0, 1, AW'(20 + s), '1, '0);
        for (int k = 1; k < 6; k++)
          cyc(k < 4 ? (m ? "R7 beat" : "R6 beat") : "R11 wrap", 0, 1, 0, '0, '1, '0);
      end
    end

    // R9 write burst with rdWr toggled during advance, then read back
    for (int m = 0; m < 2; m++) begin
      burstIlv = m[0];
      cyc("R9 wstart", 0, 0, 0, AW'(41), '0, '0);
      for (int k = 1; k < 4; k++) cyc("R9 wbeat", 0, 1, 1, '0, '0, pat(k, 11 + m));
      cyc("R9 rstart", 0, 0, 1, AW'(41), '1, pat(4, 11 + m));
      for (int k = 1; k < 4; k++) cyc("R9 rbeat", 0, 1, 0, '0, '1, '0);
    end

    // R3 stalls inside read and write bursts, garbage on all inputs while stalled
    burstIlv = 1'b0;
    cyc("R3 rstart", 0, 0, 1, AW'(9), '1, '0);
    cyc("R3 rbeat", 0, 1, 1, '0, '1, '0);
    for (int i = 0; i < 3; i++) cyc("R3 stall rd", 1, 0, 0, AW'(60), '0, '1);
    cyc("R3 resume", 0, 1, 1, '0, '1, '0);
    cyc("R3 resume", 0, 1, 1, '0, '1, '0);
    burstIlv = 1'b1;
    cyc("R3 wstart", 0, 0, 0, AW'(50), '0, '0);
    for (int i = 0; i < 2; i++) cyc("R3 stall wr", 1, 0, 1, AW'(3), '1, 32'hDEADBEEF);
    cyc("R3 wbeat", 0, 1, 1, '0, '0, pat(50, 3));
    cyc("R3 stall2", 1, 0, 1, AW'(1), '1, 32'hBAD0BAD0);
    cyc("R3 wbeat", 0, 1, 1, '0, '0, pat(51, 3));
    cyc("R3 rb", 0, 0, 1, AW'(50), '1, pat(52, 3));
    for (int k = 1; k < 4; k++) cyc("R3 rb beat", 0, 1, 0, '0, '1, '0);
    for (int k = 0; k < 4; k++) cyc("R3 verify", 0, 0, 1, AW'(48 + k), '1, '0);

    // R4 each select inactive at a cycle start; R5 deselect right after a read
    for (int s = 0; s < 3; s++) begin
      cyc("R4 desel", 0, 0, 1, AW'(5), '1, '0, s == 0, s != 1, s == 2);
      cyc("R4 desel adv", 0, 1, 1, '0, '1, '0);
      cyc("R5 rstart", 0, 0, 1, AW'(12), '1, '0);
      cyc("R5 beat", 0, 1, 1, '0, '1, '0);
      cyc("R5 desel shows pending", 0, 0, 0, AW'(13), '0, '0, s == 0, s != 1, s == 2);
      cyc("R5 after", 0, 1, 0, AW'(13), '0, '1);
      cyc("R5 after", 0, 1, 0, AW'(14), '0, '1);
    end
    cyc("R5 unchanged", 0, 0, 1, AW'(13), '1, '0);
    cyc("R5 unchanged", 0, 0, 1, AW'(14), '1, '0);

    // R8 every lane-enable pattern
    for (int p = 0; p < 16; p++) begin
      cyc("R8 wr", 0, 0, 0, AW'(30 + (p % 4)), NL'(p), '0);
      cyc("R8 rd", 0, 0, 1, AW'(30 + (p % 4)), '1, pat(p, 21));
    end
    for (int a = 30; a < 34; a++) cyc("R8 final", 0, 0, 1, AW'(a), '1, '0);
    cyc("R10 idle end", 0, 1, 1, '0, '1, '0, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule